// File: doc/BRIEF.md
# Page-Mode Program Fetch Sequencer

This block runs the external program-memory bus of a small 8-bit controller core. The core hands it a 16-bit byte address with a request/ready handshake. The block then plays out one bus cycle on two 8-bit ports:

- One output port time-multiplexes the upper and lower address bytes.
- A separate input port returns the fetched byte.
- An address-latch strobe captures the upper byte in an external latch.
- An active-low read enable opens the memory.

The block remembers which 256-byte page the external latch currently holds. A fetch into that same page skips the upper-byte phase and the latch strobe, so it takes two clocks instead of four. The short cycle is used only while the two-bit page-mode select reads 01 and the page enable bit is set. In any other setting every fetch takes the long path, and the remembered page is discarded. The core can also ask for whole stall slots, during which no fetch begins. This gives it time for multi-cycle work between fetches.

Top module: `pgfetch_top`

## Requirements
- R1: While reset is held and on the first clock after it, the read enable is high (inactive), the latch strobe is low, the result-valid output is low, and the controller reports ready.
- R2: A miss cycle lasts four clocks after acceptance. In the first clock the upper byte is on the address port with the latch strobe high. In the second clock the upper byte stays with the strobe low. In the last two clocks the lower byte is driven. The result appears four clocks after the accepting edge.
- R3: A hit cycle lasts two clocks. Only the lower byte is driven, with no latch strobe, and the result appears two clocks after the accepting edge.
- R4: The read enable is low exactly while the lower byte is driven, which is two consecutive clocks per fetch. It is never low together with the latch strobe.
- R5: A fetch is a hit only if page mode is active and its upper address byte equals the last upper byte sent with a latch strobe. The first fetch after reset is always a miss.
- R6: Page mode is active only while the select field equals 01 and the enable bit is set, and it takes effect one clock after both hold. Setting the enable with any other select value leaves every fetch a miss until the select becomes 01.
- R7: Whenever page mode is inactive, the remembered page is discarded. The first fetch after page mode is re-activated is a miss.
- R8: If a stall is requested in a clock where a fetch could be accepted, a stall slot of two clocks follows. In that slot ready is low, the read enable stays high and the latch strobe stays low. Ready is also low in any clock where a stall is requested.
- R9: The data input is captured on the edge that ends the read enable. It is reported with a one-clock valid pulse in the next clock, together with a flag that is 1 for a hit and 0 for a miss.
- R10: Ready is high only when the controller is idle, in the last clock of a fetch, or in the last clock of a stall slot, and never when a stall is requested. This allows back-to-back fetches with no gap clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Page-mode select field (01 selects the two/four clock scheme) |
| pageEn | input | 1 | Page-mode enable bit |
| reqValid | input | 1 | Fetch request present |
| reqAddr | input | 16 | Byte address of the requested fetch |
| stallReq | input | 1 | Core asks for a stall slot instead of a fetch |
| reqReady | output | 1 | Request accepted on this clock edge when reqValid is high |
| addrBus | output | 8 | Multiplexed upper/lower address byte |
| dataIn | input | 8 | Byte returned by external program memory |
| aleOut | output | 1 | Address-latch strobe for the upper byte |
| psenN | output | 1 | Active-low program memory read enable |
| fetchValid | output | 1 | One-clock pulse: fetchData and fetchHit are valid |
| fetchData | output | 8 | Captured fetched byte |
| fetchHit | output | 1 | 1 when the reported fetch used the short hit cycle |

## Verification
A wrong remembered page is the costly failure. It shows up as a fetch reported as a hit with no latch strobe while the external latch still holds another upper byte. The bench's memory model then returns a byte from the wrong page, so the data comparison fails at the very next valid pulse. The cycle count from acceptance to result fails at the same point. A mode or invalidation fault shows one fetch later, as a flag and latency mismatch on the first fetch after a mode change. A sequencing fault shows within the four clocks of the bus cycle itself, through the per-clock probes of strobe, enable, ready and address port.

// File: rtl/pgfetch_pkg.sv
package pgfetch_pkg;

  localparam logic [1:0] PAGE_MODE_TWO_FOUR = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HI_LATCH,
    ST_HI_HOLD,
    ST_LO_FIRST,
    ST_LO_LAST,
    ST_STALL
  } fetchState_t;

  typedef struct packed {
    logic loadAddr;   // take reqAddr into the address register
    logic markHit;    // accepted fetch is a page hit
    logic pageWrite;  // remember upper byte of accepted fetch
    logic pageClear;  // forget remembered page
    logic driveHi;    // upper byte on the address port
    logic driveLo;    // lower byte on the address port
    logic aleOn;      // latch strobe
    logic psenOn;     // read enable asserted
    logic capture;    // sample dataIn at the end of this clock
  } busStrobe_t;

endpackage

// File: rtl/pgfetch_ctrl.sv
module pgfetch_ctrl
  import pgfetch_pkg::*;
#(
  parameter int MODE_W     = 2,
  parameter int STALL_CLKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              pageEn,
  input  logic              reqValid,
  input  logic              stallReq,
  input  logic              pageHit,
  output logic              reqReady,
  output busStrobe_t        strobe
);

  localparam int CNT_W = (STALL_CLKS > 1) ? $clog2(STALL_CLKS) : 1;
  localparam logic [CNT_W-1:0] STALL_LAST = CNT_W'(STALL_CLKS - 1);

  fetchState_t state, stateNext;
  logic [CNT_W-1:0] stallCnt;
  logic pageActive;
  logic acceptSlot, startStall, startFetch, hitNow;

  // Mode select must read the two/four clock scheme and the enable must be set.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pageActive <= 1'b0;
    else       pageActive <= pageEn && (modeSel == MODE_W'(PAGE_MODE_TWO_FOUR));
  end

  always_comb begin
    acceptSlot = (state == ST_IDLE) || (state == ST_LO_LAST) ||
                 ((state == ST_STALL) && (stallCnt == STALL_LAST));
    startStall = acceptSlot && stallReq;
    reqReady   = acceptSlot && !stallReq;
    startFetch = reqReady && reqValid;
    hitNow     = pageActive && pageHit;
  end

  always_comb begin
    stateNext = state;
    if (startStall)      stateNext = ST_STALL;
    else if (startFetch) stateNext = hitNow ? ST_LO_FIRST : ST_HI_LATCH;
    else if (acceptSlot) stateNext = ST_IDLE;
    else begin
      unique case (state)
        ST_HI_LATCH: stateNext = ST_HI_HOLD;
        ST_HI_HOLD:  stateNext = ST_LO_FIRST;
        ST_LO_FIRST: stateNext = ST_LO_LAST;
        default:     stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stallCnt <= '0;
    end else begin
      state <= stateNext;
      if (startStall)              stallCnt <= '0;
      else if (state == ST_STALL)  stallCnt <= stallCnt + 1'b1;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.loadAddr  = startFetch;
    strobe.markHit   = startFetch && hitNow;
    strobe.pageWrite = startFetch && !hitNow && pageActive;
    strobe.pageClear = !pageActive;
    strobe.driveHi   = (state == ST_HI_LATCH) || (state == ST_HI_HOLD);
    strobe.driveLo   = (state == ST_LO_FIRST) || (state == ST_LO_LAST);
    strobe.aleOn     = (state == ST_HI_LATCH);
    strobe.psenOn    = strobe.driveLo;
    strobe.capture   = (state == ST_LO_LAST);
  end

endmodule

// File: rtl/pgfetch_dpath.sv
module pgfetch_dpath
  import pgfetch_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter bit IDLE_HIGH = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2*PORT_W-1:0] reqAddr,
  input  logic [PORT_W-1:0]   dataIn,
  input  busStrobe_t          strobe,
  output logic                pageHit,
  output logic [PORT_W-1:0]   addrBus,
  output logic                aleOut,
  output logic                psenN,
  output logic                fetchValid,
  output logic [PORT_W-1:0]   fetchData,
  output logic                fetchHit
);

  localparam int ADDR_W = 2 * PORT_W;

  logic [ADDR_W-1:0] addrReg;
  logic [PORT_W-1:0] pageHi;
  logic              pageValid;
  logic              hitReg;
  logic [PORT_W-1:0] idleLevel;

  generate
    if (IDLE_HIGH) begin : g_idleHigh
      assign idleLevel = '1;
    end else begin : g_idleLow
      assign idleLevel = '0;
    end
  endgenerate

  assign pageHit = pageValid && (reqAddr[ADDR_W-1:PORT_W] == pageHi);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      pageHi    <= '0;
      pageValid <= 1'b0;
      hitReg    <= 1'b0;
    end else begin
      if (strobe.loadAddr) begin
        addrReg <= reqAddr;
        hitReg  <= strobe.markHit;
      end
      if (strobe.pageClear) pageValid <= 1'b0;
      else if (strobe.pageWrite) begin
        pageHi    <= reqAddr[ADDR_W-1:PORT_W];
        pageValid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchValid <= 1'b0;
      fetchData  <= '0;
      fetchHit   <= 1'b0;
    end else begin
      fetchValid <= strobe.capture;
      if (strobe.capture) begin
        fetchData <= dataIn;
        fetchHit  <= hitReg;
      end
    end
  end

  always_comb begin
    if (strobe.driveHi)      addrBus = addrReg[ADDR_W-1:PORT_W];
    else if (strobe.driveLo) addrBus = addrReg[PORT_W-1:0];
    else                     addrBus = idleLevel;
    aleOut = strobe.aleOn;
    psenN  = !strobe.psenOn;
  end

endmodule

// File: rtl/pgfetch_top.sv
module pgfetch_top
  import pgfetch_pkg::*;
#(
  parameter int PORT_W     = 8,
  parameter int MODE_W     = 2,
  parameter int STALL_CLKS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [MODE_W-1:0]   modeSel,
  input  logic                pageEn,
  input  logic                reqValid,
  input  logic [2*PORT_W-1:0] reqAddr,
  input  logic                stallReq,
  output logic                reqReady,
  output logic [PORT_W-1:0]   addrBus,
  input  logic [PORT_W-1:0]   dataIn,
  output logic                aleOut,
  output logic                psenN,
  output logic                fetchValid,
  output logic [PORT_W-1:0]   fetchData,
  output logic                fetchHit
);

  busStrobe_t strobe;
  logic       pageHit;

  pgfetch_ctrl #(.MODE_W(MODE_W), .STALL_CLKS(STALL_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .pageEn(pageEn),
    .reqValid(reqValid), .stallReq(stallReq), .pageHit(pageHit),
    .reqReady(reqReady), .strobe(strobe)
  );

  pgfetch_dpath #(.PORT_W(PORT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .dataIn(dataIn),
    .strobe(strobe), .pageHit(pageHit), .addrBus(addrBus),
    .aleOut(aleOut), .psenN(psenN), .fetchValid(fetchValid),
    .fetchData(fetchData), .fetchHit(fetchHit)
  );

endmodule

// File: rtl/pgfetch_chk.sv
module pgfetch_chk (
  input logic clk,
  input logic rstN,
  input logic stallReq,
  input logic reqReady,
  input logic aleOut,
  input logic psenN,
  input logic fetchValid,
  input logic fetchHit
);

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    aleOut |=> (!aleOut && psenN));

  // R4
  ale_psen_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    aleOut |-> psenN);

  // R4
  psen_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(psenN) |=> !psenN);

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |=> !fetchValid);

  // R9
  valid_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> $past(!psenN));

  // R3
  hit_no_ale_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchHit) |-> (!$past(aleOut) && !$past(aleOut, 2)));

  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallReq |-> !reqReady);

  // R10
  ready_no_ale_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !aleOut);

endmodule

bind pgfetch_top pgfetch_chk u_chk (
  .clk(clk), .rstN(rstN), .stallReq(stallReq), .reqReady(reqReady),
  .aleOut(aleOut), .psenN(psenN), .fetchValid(fetchValid), .fetchHit(fetchHit)
);

// File: tb/tb_pgfetch_top.sv
module tb_pgfetch_top;

  typedef struct {
    logic [7:0] data;
    logic       hit;
    int         due;
    logic [15:0] addr;
  } sbItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic        pageEn = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic        stallReq = 1'b0;
  logic        reqReady, aleOut, psenN, fetchValid, fetchHit;
  logic [7:0]  addrBus, dataIn, fetchData;
  logic [7:0]  extHi = 8'h00;
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  sbItem_t     sbQ[$];

  always #10 clk = ~clk;

  pgfetch_top dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .pageEn(pageEn),
    .reqValid(reqValid), .reqAddr(reqAddr), .stallReq(stallReq),
    .reqReady(reqReady), .addrBus(addrBus), .dataIn(dataIn),
    .aleOut(aleOut), .psenN(psenN), .fetchValid(fetchValid),
    .fetchData(fetchData), .fetchHit(fetchHit)
  );

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[15:8] ^ (a[7:0] * 8'd7) ^ 8'h5A;
  endfunction

  // External memory model: address latch plus byte-wide program memory.
  always @(negedge clk) if (aleOut) extHi <= addrBus;
  assign dataIn = !psenN ? memByte({extHi, addrBus}) : 8'h00;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Monitor: pops the scoreboard on every valid pulse.
  always @(negedge clk) begin
    if (rstN) begin
      if (fetchValid) begin
        if (sbQ.size() == 0) chk(1'b0, "R9 unexpected valid pulse", 1, 0);
        else begin
          sbItem_t it;
          it = sbQ.pop_front();
          chk(fetchData == it.data, "R9 fetched byte", fetchData, it.data);
          chk(fetchHit == it.hit, "R5 hit flag", fetchHit, it.hit);
          chk(cyc == it.due, it.hit ? "R3 hit latency" : "R2 miss latency", cyc, it.due);
        end
      end else if (sbQ.size() != 0 && cyc > sbQ[0].due) begin
        chk(1'b0, "R9 missing valid pulse", sbQ[0].addr, sbQ[0].due);
        void'(sbQ.pop_front());
      end
    end
  end

  // Driver: presents a request, waits for acceptance, queues the expectation.
  task automatic fetch(input logic [15:0] a, input logic expHit);
    sbItem_t it;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    it.data = memByte(a);
    it.hit  = expHit;
    it.due  = cyc + (expHit ? 2 : 4);
    it.addr = a;
    sbQ.push_back(it);
  endtask

  task automatic drain();
    while (sbQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Called right after a miss is accepted: per-clock bus shape (R2, R4, R10).
  task automatic probeMiss(input logic [15:0] a);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(aleOut == (k == 0), "R2 latch strobe slot", aleOut, (k == 0));
      chk(psenN == (k < 2), "R4 read enable slot", psenN, (k < 2));
      chk(addrBus == ((k < 2) ? a[15:8] : a[7:0]), "R2 address byte", addrBus,
          (k < 2) ? a[15:8] : a[7:0]);
      chk(reqReady == (k == 3), "R10 ready slot", reqReady, (k == 3));
    end
  endtask

  task automatic probeHit(input logic [15:0] a);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(aleOut == 1'b0, "R3 no latch strobe", aleOut, 0);
      chk(psenN == 1'b0, "R4 read enable on hit", psenN, 0);
      chk(addrBus == a[7:0], "R3 lower byte", addrBus, a[7:0]);
      chk(reqReady == (k == 1), "R10 ready slot on hit", reqReady, (k == 1));
    end
  endtask

  task automatic setMode(input logic [1:0] m, input logic en);
    drain();
    modeSel = m;
    pageEn  = en;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: values under reset
    chk(psenN == 1'b1 && aleOut == 1'b0 && fetchValid == 1'b0, "R1 strobes in reset",
        {psenN, aleOut, fetchValid}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);

    setMode(2'b01, 1'b1);
    // R5: first fetch after reset misses
    fetch(16'h1234, 1'b0); probeMiss(16'h1234);
    fetch(16'h1235, 1'b1); probeHit(16'h1235);
    fetch(16'h12FF, 1'b1);
    fetch(16'h1300, 1'b0);
    // R10: back-to-back stream, including a long jump to another page
    fetch(16'h1301, 1'b1);
    fetch(16'h1302, 1'b1);
    fetch(16'h4567, 1'b0);
    fetch(16'h4500, 1'b1);
    fetch(16'h1303, 1'b0);
    drain();

    // R8: stall slot in an idle accept clock
    stallReq = 1'b1;
    reqValid = 1'b1;
    reqAddr  = 16'h1304;
    #1;
    chk(reqReady == 1'b0, "R8 ready with stall request", reqReady, 0);
    @(posedge clk); #1;
    stallReq = 1'b0;
    reqValid = 1'b0;
    @(negedge clk);
    chk(reqReady == 1'b0 && psenN == 1'b1 && aleOut == 1'b0, "R8 first stall clock",
        {reqReady, psenN, aleOut}, 3'b010);
    @(negedge clk);
    chk(reqReady == 1'b1 && psenN == 1'b1, "R8 last stall clock",
        {reqReady, psenN}, 2'b11);
    fetch(16'h1304, 1'b1);
    drain();

    // R7: disabling forgets the page; disabled fetches always miss
    setMode(2'b01, 1'b0);
    fetch(16'h1305, 1'b0);
    fetch(16'h1306, 1'b0);
    setMode(2'b01, 1'b1);
    fetch(16'h1307, 1'b0);
    fetch(16'h1308, 1'b1);

    // R6: enable with another select value gives no short cycle
    setMode(2'b10, 1'b1);
    fetch(16'h1309, 1'b0);
    fetch(16'h130A, 1'b0);
    setMode(2'b00, 1'b1);
    fetch(16'h130B, 1'b0);
    setMode(2'b01, 1'b1);
    fetch(16'h130C, 1'b0);
    fetch(16'h130D, 1'b1);
    drain();

    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, pending=%0d expected=0", sbQ.size());
    summary();
    $finish;
  end

endmodule